// File: doc/BRIEF.md
# Memory Controller Control and Status Registers

This block is the register file that software uses to configure and observe an error-correcting memory controller. It sits on a simple 32-bit register bus with byte addresses. The word index is the byte address divided by four. Nine 32-bit registers are decoded: enable, delay, fault status, video configuration, two fault address registers, diagnostic, and two event counters. Each register applies its own write rule. The version and implementation identity fields cannot be written. The fault address registers can only be loaded by the hardware fault capture port.

The memory datapath reports a detected error through a one-cycle capture strobe. The strobe carries error flags, a double-word index, a syndrome and two address words. Software clears status bits by writing ones to them. An interrupt output is raised while a correctable error is pending and the correctable-error interrupt enable is set. One hardware variant, chosen when the version parameter is zero, also decodes a four-byte diagnostic window at offset 0x1000 from the register base.

Top module: `memctl_csr`

## Requirements
- R1: After reset, the registers read as follows. Index 0 (enable) reads {IMPL[3:0], VERSION[3:0], 24'h0003FC}. Index 1 (delay) reads 0x00000020. Index 4 (fault address 0) reads 0x07C00000. Indices 2, 3, 5, 6, 7 and 8 read zero.
- R2: A write to index 0 stores wdata[23:0]. Bits 31:28 (implementation) and 27:24 (version) keep their built-in values.
- R3: A write to index 1 stores wdata with bit 31 forced to zero.
- R4: Writes to index 4 and index 5 have no effect. These registers change only on a fault capture.
- R5: Index 3 (video configuration), index 6 (diagnostic), index 7 (event count 0) and index 8 (event count 1) each store and return a full 32-bit word, independently of the others.
- R6: The rdata and rvalid outputs are registered. rvalid is high exactly one cycle after a cycle with rd_en, and low otherwise.
- R7: Word indices 9 and above outside the diagnostic window read zero, and writes to them change no register.
- R8: When flt_valid is high, the fault status register is updated as follows:
  - flt_flags bits 3:0 (correctable, bad slot, write timeout, uncorrectable) are ORed into status bits 3:0.
  - flt_flags bit 4 is ORed into status bit 17 (graphics error).
  - flt_dw loads status bits 7:4, and flt_synd loads status bits 15:8.
  - Status bit 16 (multiple errors) is set when status bit 0 or bit 3 is already set and the capture carries flag 0 or flag 3.
  - Index 4 and index 5 load flt_addr0 and flt_addr1.
  - Status bits 31:18 read zero.
- R9: Writing to index 2 clears every status bit whose wdata bit is one. When a capture occurs in the same cycle, the captured bits are applied after the clear.
- R10: irq is high exactly while status bit 0 and enable bit 1 are both one.
- R11: When VERSION is 0, a write to byte address 0x1000+n (n = addr[1:0]) stores wdata[7:0] in diagnostic byte n. A read of that address returns the byte zero-extended. All four bytes reset to zero.
- R12: When VERSION is not 0, the diagnostic window is absent. Reads of it return zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| flt_valid | input | 1 | Fault capture strobe |
| flt_flags | input | 5 | {graphics, uncorrectable, timeout, bad slot, correctable} |
| flt_dw | input | 4 | Double-word index of the fault |
| flt_synd | input | 8 | Syndrome of the fault |
| flt_addr0 | input | 32 | Fault address word 0 |
| flt_addr1 | input | 32 | Fault address word 1 |
| irq | output | 1 | Correctable-error interrupt |

## Verification
The main behaviour is exercised with several kinds of write data:
- All-ones words expose every bit that a write mask must protect: the identity byte of the enable register, bit 31 of the delay register, and the whole of the fault address registers.
- Distinct patterns in the four plain registers separate the two event counters, which catches aliasing between them.

Fault captures are exercised in three sequences:
- A correctable error alone.
- A correctable error followed by an uncorrectable one, which tells a first error apart from a multiple-error condition.
- A capture coinciding with a clearing write, which settles their order.

A second instance built with a nonzero version checks that the diagnostic window is absent.

// File: rtl/memctl_csr_pkg.sv
package memctl_csr_pkg;

    localparam int NUM_REGS = 9;
    localparam int FST_W    = 18;

    typedef enum logic [3:0] {
        IDX_EN  = 4'd0,
        IDX_DLY = 4'd1,
        IDX_FST = 4'd2,
        IDX_VCR = 4'd3,
        IDX_FA0 = 4'd4,
        IDX_FA1 = 4'd5,
        IDX_DR  = 4'd6,
        IDX_EC0 = 4'd7,
        IDX_EC1 = 4'd8
    } reg_idx_e;

    localparam logic [31:0] DLY_WMASK  = 32'h7FFF_FFFF;
    localparam logic [31:0] DLY_RST    = 32'h0000_0020;
    localparam logic [31:0] FA0_RST    = 32'h07C0_0000;
    localparam logic [23:0] EN_LOW_RST = 24'h0003FC;

    localparam int ST_CE  = 0;
    localparam int ST_UE  = 3;
    localparam int ST_ME  = 16;
    localparam int ST_GFX = 17;

    typedef struct packed {
        logic [31:0] en;
        logic [31:0] dly;
        logic [31:0] vcr;
        logic [31:0] dr;
        logic [31:0] ec0;
        logic [31:0] ec1;
    } cfg_regs_t;

    typedef struct packed {
        logic [FST_W-1:0] st;
        logic [31:0]      a0;
        logic [31:0]      a1;
    } fault_regs_t;

endpackage

// File: rtl/memctl_addr_dec.sv
module memctl_addr_dec
    import memctl_csr_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int DIAG_OFF   = 'h1000,
    parameter int DIAG_BYTES = 4,
    parameter bit DIAG_EN    = 1'b1
) (
    input  logic [ADDR_W-1:0]             addr,
    output logic                          reg_hit,
    output reg_idx_e                      idx,
    output logic                          diag_hit,
    output logic [$clog2(DIAG_BYTES)-1:0] diag_sel
);
    localparam int                DSEL_W    = $clog2(DIAG_BYTES);
    localparam logic [ADDR_W-1:0] DIAG_BASE = ADDR_W'(DIAG_OFF);
    localparam logic [ADDR_W-3:0] NREG      = (ADDR_W-2)'(NUM_REGS);

    logic [ADDR_W-3:0] word;

    always_comb begin
        word     = addr[ADDR_W-1:2];
        reg_hit  = (word < NREG);
        idx      = reg_idx_e'(word[3:0]);
        diag_hit = DIAG_EN && (addr[ADDR_W-1:DSEL_W] == DIAG_BASE[ADDR_W-1:DSEL_W]);
        diag_sel = addr[DSEL_W-1:0];
    end
endmodule

// File: rtl/memctl_fault_rec.sv
module memctl_fault_rec
    import memctl_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_en,
    input  logic [FST_W-1:0] clr_mask,
    input  logic             flt_valid,
    input  logic [4:0]       flt_flags,
    input  logic [3:0]       flt_dw,
    input  logic [7:0]       flt_synd,
    input  logic [31:0]      flt_addr0,
    input  logic [31:0]      flt_addr1,
    output logic [FST_W-1:0] fst_q,
    output logic [31:0]      fa0_q,
    output logic [31:0]      fa1_q
);
    fault_regs_t flt_d, flt_q;
    logic        had_err, new_err;

    always_comb begin
        flt_d   = flt_q;
        had_err = 1'b0;
        new_err = 1'b0;
        if (clr_en) begin
            flt_d.st = flt_q.st & ~clr_mask;
        end
        if (flt_valid) begin
            had_err              = flt_d.st[ST_CE] | flt_d.st[ST_UE];
            new_err              = flt_flags[0] | flt_flags[3];
            flt_d.st[3:0]        = flt_d.st[3:0] | flt_flags[3:0];
            flt_d.st[ST_GFX]     = flt_d.st[ST_GFX] | flt_flags[4];
            flt_d.st[7:4]        = flt_dw;
            flt_d.st[15:8]       = flt_synd;
            if (had_err && new_err) begin
                flt_d.st[ST_ME] = 1'b1;
            end
            flt_d.a0 = flt_addr0;
            flt_d.a1 = flt_addr1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_q <= '{st: '0, a0: FA0_RST, a1: '0};
        end else begin
            flt_q <= flt_d;
        end
    end

    assign fst_q = flt_q.st;
    assign fa0_q = flt_q.a0;
    assign fa1_q = flt_q.a1;
endmodule

// File: rtl/memctl_diag_win.sv
module memctl_diag_win #(
    parameter int DIAG_BYTES = 4,
    parameter bit PRESENT    = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic [$clog2(DIAG_BYTES)-1:0] sel,
    input  logic [7:0]                    wbyte,
    output logic [7:0]                    rbyte
);
    generate
        if (PRESENT) begin : g_win
            logic [7:0] mem_d [DIAG_BYTES];
            logic [7:0] mem_q [DIAG_BYTES];

            always_comb begin
                mem_d = mem_q;
                if (wr) begin
                    mem_d[sel] = wbyte;
                end
            end

            always_ff @(posedge clk) begin
                for (int i = 0; i < DIAG_BYTES; i++) begin
                    mem_q[i] <= rst_n ? mem_d[i] : 8'h00;
                end
            end

            assign rbyte = mem_q[sel];
        end else begin : g_none
            logic unused_win;
            assign unused_win = ^{clk, rst_n, wr, sel, wbyte};
            assign rbyte      = 8'h00;
        end
    endgenerate
endmodule

// File: rtl/memctl_csr.sv
module memctl_csr
    import memctl_csr_pkg::*;
#(
    parameter int         ADDR_W     = 13,
    parameter logic [3:0] VERSION    = 4'h0,
    parameter logic [3:0] IMPL       = 4'h0,
    parameter int         DIAG_OFF   = 'h1000,
    parameter int         DIAG_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              rvalid,
    input  logic              flt_valid,
    input  logic [4:0]        flt_flags,
    input  logic [3:0]        flt_dw,
    input  logic [7:0]        flt_synd,
    input  logic [31:0]       flt_addr0,
    input  logic [31:0]       flt_addr1,
    output logic              irq
);
    localparam bit DIAG_EN = (VERSION == 4'h0);
    localparam int DSEL_W  = $clog2(DIAG_BYTES);

    typedef struct packed {
        cfg_regs_t   cfg;
        logic        rv;
        logic [31:0] rdat;
    } ctl_t;

    ctl_t               ctl_d, ctl_q;
    logic               reg_hit, diag_hit;
    reg_idx_e           idx;
    logic [DSEL_W-1:0]  diag_sel;
    logic [7:0]         diag_rbyte;
    logic [FST_W-1:0]   fst_q;
    logic [31:0]        fa0_q, fa1_q;
    logic [31:0]        en_q, dly_q;
    logic               fst_wr;

    memctl_addr_dec #(
        .ADDR_W(ADDR_W), .DIAG_OFF(DIAG_OFF),
        .DIAG_BYTES(DIAG_BYTES), .DIAG_EN(DIAG_EN)
    ) u_dec (
        .addr(addr), .reg_hit(reg_hit), .idx(idx),
        .diag_hit(diag_hit), .diag_sel(diag_sel)
    );

    assign fst_wr = wr_en && reg_hit && (idx == IDX_FST);

    memctl_fault_rec u_flt (
        .clk(clk), .rst_n(rst_n),
        .clr_en(fst_wr), .clr_mask(wdata[FST_W-1:0]),
        .flt_valid(flt_valid), .flt_flags(flt_flags),
        .flt_dw(flt_dw), .flt_synd(flt_synd),
        .flt_addr0(flt_addr0), .flt_addr1(flt_addr1),
        .fst_q(fst_q), .fa0_q(fa0_q), .fa1_q(fa1_q)
    );

    memctl_diag_win #(
        .DIAG_BYTES(DIAG_BYTES), .PRESENT(DIAG_EN)
    ) u_diag (
        .clk(clk), .rst_n(rst_n),
        .wr(wr_en && diag_hit), .sel(diag_sel),
        .wbyte(wdata[7:0]), .rbyte(diag_rbyte)
    );

    assign en_q  = ctl_q.cfg.en;
    assign dly_q = ctl_q.cfg.dly;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en && reg_hit) begin
            case (idx)
                IDX_EN:  ctl_d.cfg.en  = {en_q[31:24], wdata[23:0]};
                IDX_DLY: ctl_d.cfg.dly = wdata & DLY_WMASK;
                IDX_VCR: ctl_d.cfg.vcr = wdata;
                IDX_DR:  ctl_d.cfg.dr  = wdata;
                IDX_EC0: ctl_d.cfg.ec0 = wdata;
                IDX_EC1: ctl_d.cfg.ec1 = wdata;
                default: ;
            endcase
        end
        ctl_d.rv   = rd_en;
        ctl_d.rdat = '0;
        if (rd_en && reg_hit) begin
            case (idx)
                IDX_EN:  ctl_d.rdat = en_q;
                IDX_DLY: ctl_d.rdat = dly_q;
                IDX_FST: ctl_d.rdat = {{(32-FST_W){1'b0}}, fst_q};
                IDX_VCR: ctl_d.rdat = ctl_q.cfg.vcr;
                IDX_FA0: ctl_d.rdat = fa0_q;
                IDX_FA1: ctl_d.rdat = fa1_q;
                IDX_DR:  ctl_d.rdat = ctl_q.cfg.dr;
                IDX_EC0: ctl_d.rdat = ctl_q.cfg.ec0;
                IDX_EC1: ctl_d.rdat = ctl_q.cfg.ec1;
                default: ctl_d.rdat = '0;
            endcase
        end else if (rd_en && diag_hit) begin
            ctl_d.rdat = {24'h0, diag_rbyte};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.cfg.en  <= {IMPL, VERSION, EN_LOW_RST};
            ctl_q.cfg.dly <= DLY_RST;
            ctl_q.cfg.vcr <= '0;
            ctl_q.cfg.dr  <= '0;
            ctl_q.cfg.ec0 <= '0;
            ctl_q.cfg.ec1 <= '0;
            ctl_q.rv      <= 1'b0;
            ctl_q.rdat    <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rdata  = ctl_q.rdat;
    assign rvalid = ctl_q.rv;
    assign irq    = fst_q[ST_CE] & en_q[1];
endmodule

// File: rtl/memctl_csr_chk.sv
module memctl_csr_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              rvalid,
    input logic              flt_valid,
    input logic [4:0]        flt_flags,
    input logic              irq,
    input logic [31:0]       en_q,
    input logic [31:0]       dly_q,
    input logic [17:0]       fst_q,
    input logic [31:0]       fa0_q
);
    // R6
    rd_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);

    // R6
    idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);

    // R2
    ident_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> $stable(en_q[31:24]));

    // R3
    dly_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dly_q[31]);

    // R4
    fa0_capture_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_valid |=> $stable(fa0_q));

    // R8
    ce_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_flags[0]) |=> fst_q[0]);

    // R9
    ce_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(8) && wdata[0] && !flt_valid) |=> !fst_q[0]);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> en_q[1]);
endmodule

bind memctl_csr memctl_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rvalid(rvalid),
    .flt_valid(flt_valid), .flt_flags(flt_flags), .irq(irq),
    .en_q(en_q), .dly_q(dly_q), .fst_q(fst_q), .fa0_q(fa0_q)
);

// File: tb/memctl_csr_test.sv
`timescale 1ns/1ps
module memctl_csr_test;
    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic          flt_valid = 1'b0;
    logic [4:0]    flt_flags = '0;
    logic [3:0]    flt_dw = '0;
    logic [7:0]    flt_synd = '0;
    logic [31:0]   flt_addr0 = '0, flt_addr1 = '0;
    logic [31:0]   rdata, v1_rdata;
    logic          rvalid, v1_rvalid, irq, v1_irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic [31:0] mon_exp;
    string       mon_tag;

    always #4 clk = ~clk;

    memctl_csr #(.ADDR_W(AW), .VERSION(4'h0), .IMPL(4'h2)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .flt_valid(flt_valid),
        .flt_flags(flt_flags), .flt_dw(flt_dw), .flt_synd(flt_synd),
        .flt_addr0(flt_addr0), .flt_addr1(flt_addr1), .irq(irq)
    );

    memctl_csr #(.ADDR_W(AW), .VERSION(4'h1), .IMPL(4'h0)) uut_v1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(v1_rdata), .rvalid(v1_rvalid), .flt_valid(flt_valid),
        .flt_flags(flt_flags), .flt_dw(flt_dw), .flt_synd(flt_synd),
        .flt_addr0(flt_addr0), .flt_addr1(flt_addr1), .irq(v1_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_both(input logic [AW-1:0] a, input logic [31:0] e,
                           input logic [31:0] e_v1, input string tag);
        rd(a, e, tag);
        check({tag, " variant1"}, v1_rdata, e_v1);
    endtask

    task automatic cap(input logic [4:0] f, input logic [3:0] dw, input logic [7:0] sy,
                       input logic [31:0] a0, input logic [31:0] a1);
        @(negedge clk);
        flt_valid = 1'b1; flt_flags = f; flt_dw = dw; flt_synd = sy;
        flt_addr0 = a0; flt_addr1 = a1;
        @(negedge clk);
        flt_valid = 1'b0;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R6 actual unexpected rvalid expected none");
            end else begin
                mon_exp = exp_q.pop_front();
                mon_tag = tag_q.pop_front();
                check(mon_tag, rdata, mon_exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R6 watchdog actual hang expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 idle rvalid", {31'b0, rvalid}, 32'h0);
        check("R10 reset irq", {31'b0, irq}, 32'h0);

        // R1 reset values
        rd_both(13'h000, 32'h2000_03FC, 32'h0100_03FC, "R1 enable");
        rd(13'h004, 32'h0000_0020, "R1 delay");
        rd(13'h008, 32'h0, "R1 status");
        rd(13'h00C, 32'h0, "R1 vcr");
        rd(13'h010, 32'h07C0_0000, "R1 fa0");
        rd(13'h014, 32'h0, "R1 fa1");
        rd(13'h018, 32'h0, "R1 diag reg");
        rd(13'h01C, 32'h0, "R1 ec0");
        rd(13'h020, 32'h0, "R1 ec1");
        rd(13'h1000, 32'h0, "R11 window reset");

        // R2 identity fields
        wr(13'h000, 32'hFFFF_FFFF);
        rd(13'h000, 32'h20FF_FFFF, "R2 all ones");
        wr(13'h000, 32'h0000_0002);
        rd(13'h000, 32'h2000_0002, "R2 low pattern");

        // R3 delay mask
        wr(13'h004, 32'hFFFF_FFFF);
        rd(13'h004, 32'h7FFF_FFFF, "R3 all ones");
        wr(13'h004, 32'h1234_5678);
        rd(13'h004, 32'h1234_5678, "R3 pattern");

        // R4 fault address not writable
        wr(13'h010, 32'hFFFF_FFFF);
        wr(13'h014, 32'hFFFF_FFFF);
        rd(13'h010, 32'h07C0_0000, "R4 fa0 write ignored");
        rd(13'h014, 32'h0, "R4 fa1 write ignored");

        // R5 plain registers, event counters kept apart
        wr(13'h00C, 32'hA1A1_0001);
        wr(13'h018, 32'hB2B2_0002);
        wr(13'h01C, 32'hC3C3_0003);
        wr(13'h020, 32'hD4D4_0004);
        rd(13'h00C, 32'hA1A1_0001, "R5 vcr");
        rd(13'h018, 32'hB2B2_0002, "R5 diag reg");
        rd(13'h01C, 32'hC3C3_0003, "R5 ec0");
        rd(13'h020, 32'hD4D4_0004, "R5 ec1");

        // R7 unmapped
        wr(13'h024, 32'h5555_5555);
        rd(13'h024, 32'h0, "R7 index 9");
        rd(13'h03C, 32'h0, "R7 index 15");
        rd(13'h0800, 32'h0, "R7 far index");
        rd(13'h00C, 32'hA1A1_0001, "R7 vcr untouched");

        // R8 correctable capture
        cap(5'b00001, 4'h3, 8'hA5, 32'h1111_2222, 32'h3333_4444);
        check("R10 irq after ce", {31'b0, irq}, 32'h1);
        rd(13'h008, 32'h0000_A531, "R8 ce status");
        rd(13'h010, 32'h1111_2222, "R4 fa0 captured");
        rd(13'h014, 32'h3333_4444, "R8 fa1 captured");

        // R8 multiple errors
        cap(5'b01000, 4'h1, 8'h3C, 32'h5, 32'h6);
        rd(13'h008, 32'h0001_3C19, "R8 multiple errors");

        // R10 interrupt gated by enable bit 1
        wr(13'h000, 32'h0);
        check("R10 irq disabled", {31'b0, irq}, 32'h0);
        wr(13'h000, 32'h2);
        check("R10 irq re-enabled", {31'b0, irq}, 32'h1);

        // R9 write one to clear
        wr(13'h008, 32'h0000_0001);
        check("R9 irq after clear", {31'b0, irq}, 32'h0);
        rd(13'h008, 32'h0001_3C18, "R9 clear ce only");
        wr(13'h008, 32'hFFFF_FFFF);
        rd(13'h008, 32'h0, "R9 clear all");

        // R9 capture wins over same-cycle clear
        @(negedge clk);
        wr_en = 1'b1; addr = 13'h008; wdata = 32'h1;
        flt_valid = 1'b1; flt_flags = 5'b00001; flt_dw = 4'h0; flt_synd = 8'h00;
        @(negedge clk);
        wr_en = 1'b0; flt_valid = 1'b0;
        check("R9 irq after collision", {31'b0, irq}, 32'h1);
        rd(13'h008, 32'h0000_0001, "R9 capture after clear");

        // R8 graphics flag
        cap(5'b10000, 4'h0, 8'h00, 32'h7, 32'h8);
        rd(13'h008, 32'h0002_0001, "R8 graphics flag");

        // R11 / R12 diagnostic window
        wr(13'h1001, 32'h0000_00AB);
        wr(13'h1003, 32'h0000_005C);
        wr(13'h1002, 32'h0000_0123);
        rd_both(13'h1001, 32'h0000_00AB, 32'h0, "R12 R11 byte 1");
        rd_both(13'h1003, 32'h0000_005C, 32'h0, "R12 R11 byte 3");
        rd_both(13'h1002, 32'h0000_0023, 32'h0, "R12 R11 byte 2");
        rd(13'h1000, 32'h0, "R11 byte 0 untouched");
        rd_both(13'h000, 32'h2000_0002, 32'h0100_0002, "R12 enable intact");

        repeat (3) @(negedge clk);
        check("R6 no pending reads", exp_q.size(), 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule